// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block carries out cache maintenance over a span of physical memory on request from software. Software programs a first address and an exclusive limit address through a small 64-bit register window, then writes a control word that selects the maintenance kind and sets a launch bit. The sequencer rounds the first address down to a 64-byte line boundary and walks the span one line at a time. For each line it presents one request to the cache over a valid/ready handshake.

Three maintenance kinds exist: write back dirty data and drop the line, drop the line without writing it back, and write back while keeping the line valid and shared. The launch bit doubles as the busy flag. It reads back as 1 while lines remain and falls to 0 by itself once the walk ends, so software only has to poll the control word. A single-cycle completion strobe is also brought out for hardware that waits on the walk.

Top module: `cmo_range_engine`

## Requirements
- R1: After synchronous reset, and also when reset is applied in the middle of a walk, busy, done and line_valid are 0, and the three registers read back as zero.
- R2: The register at offset 0x00 holds the first address and the register at 0x08 holds the limit address. Each keeps only bits [39:0] of the written data and reads back with bits [63:40] as zero.
- R3: The control register at offset 0x10 has bit 0 as launch/busy and bits [2:1] as the maintenance kind. A read returns the live busy flag in bit 0, the latched kind in bits [2:1], and zero in all other bits. A control write with bit 0 clear stores the kind without starting a walk.
- R4: Only a control write with bit 0 set, made while idle, starts a walk. busy reads 1 in the cycle after that write. Writes to the address registers never start a walk.
- R5: Requests begin at the first address rounded down to a multiple of 64 and step by 0x40. A line is requested only while its base is strictly below the limit address. The line address always has bits [5:0] clear.
- R6: line_op carries the kind code for every request: 0 means write back and drop, 1 means drop without write-back, 2 means write back and keep the line shared.
- R7: A request holds line_valid, line_addr and line_op steady until line_ready is sampled high. Only then does the sequencer move to the next line.
- R8: When the limit is not above the rounded first address, no request is issued and busy stays high for exactly one cycle.
- R9: Kind code 3 is reserved. A walk launched with it issues no request and keeps busy high for exactly one cycle.
- R10: done pulses for one cycle, during the last cycle in which busy is 1, and busy reads 0 on the next cycle. A walk of N lines with S stalled cycles keeps busy high for N+S+1 cycles.
- R11: While busy, writes to the two address registers and to the control register are ignored. The stored addresses, the latched kind and the request in flight do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for reads and writes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| line_valid | output | 1 | A line maintenance request is presented |
| line_addr | output | 40 | Base address of the requested line |
| line_op | output | 2 | Maintenance kind of the request |
| line_ready | input | 1 | Cache accepts the presented request |
| busy | output | 1 | Walk in progress (same as control bit 0) |
| done | output | 1 | Final cycle of a walk |

## Verification
A wrong line pointer shows up at line_addr in the very cycle after the faulty handshake. The bench predicts every line base from the rounded first address and compares each one, so a skipped, repeated or misaligned line is caught at once. A wrong end test or a wrong reserved-kind decision changes how many requests are issued and how long busy stays high. The bench compares both counts against figures it derives from the programmed span. Register corruption while busy is caught by reading the window back mid-walk and by watching the pending request stay frozen while line_ready is held low.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_FIRST = 5'h00;
    localparam logic [REG_AW-1:0] OFS_LIMIT = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h10;

    // maintenance kinds, encoded as in control bits [2:1]
    typedef enum logic [1:0] {
        OP_FLUSH_DROP = 2'd0,
        OP_DROP       = 2'd1,
        OP_WRITEBACK  = 2'd2,
        OP_RESERVED   = 2'd3
    } cmo_op_e;

    typedef struct packed {
        cmo_op_e kind;
        logic    launch;
    } ctrl_word_t;

    function automatic ctrl_word_t unpack_ctrl(input logic [2:0] low_bits);
        ctrl_word_t c;
        c.launch = low_bits[0];
        c.kind   = cmo_op_e'(low_bits[2:1]);
        return c;
    endfunction

    function automatic logic kind_runs(input cmo_op_e k);
        return k != OP_RESERVED;
    endfunction

endpackage

// File: rtl/cmo_csr.sv
module cmo_csr
    import cmo_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     busy,
    output logic [ADDR_W-1:0]        first_q,
    output logic [ADDR_W-1:0]        limit_q,
    output cmo_op_e                  kind_q,
    output logic                     launch
);

    localparam int ADDR_PAD = DATA_W - ADDR_W;
    localparam int CTRL_PAD = DATA_W - 3;

    ctrl_word_t ctrl_in;
    logic       wr_first, wr_limit, wr_ctrl;
    logic       unused_hi;

    assign ctrl_in  = unpack_ctrl(reg_wdata[2:0]);
    assign wr_first = reg_we && (reg_addr == OFS_FIRST) && !busy;
    assign wr_limit = reg_we && (reg_addr == OFS_LIMIT) && !busy;
    assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL)  && !busy;
    assign launch   = wr_ctrl && ctrl_in.launch;
    assign unused_hi = ^reg_wdata[DATA_W-1:ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            limit_q <= '0;
            kind_q  <= OP_FLUSH_DROP;
        end else begin
            if (wr_first) first_q <= reg_wdata[ADDR_W-1:0];
            if (wr_limit) limit_q <= reg_wdata[ADDR_W-1:0];
            if (wr_ctrl)  kind_q  <= ctrl_in.kind;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_FIRST: reg_rdata = {{ADDR_PAD{1'b0}}, first_q};
            OFS_LIMIT: reg_rdata = {{ADDR_PAD{1'b0}}, limit_q};
            OFS_CTRL:  reg_rdata = {{CTRL_PAD{1'b0}}, kind_q, busy};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmo_walker.sv
module cmo_walker
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] first_q,
    input  logic [ADDR_W-1:0] limit_q,
    input  cmo_op_e           kind_q,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_op,
    input  logic              req_ready,
    output logic              busy,
    output logic              done
);

    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int CUR_W = ADDR_W + 1;   // one spare bit so the top line cannot wrap
    localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

    logic             run_q;
    logic [CUR_W-1:0] cur_q;
    logic [CUR_W-1:0] base_line;
    logic             in_span, issue, fire, finish;

    assign base_line = {1'b0, first_q & LINE_MASK};
    assign in_span   = cur_q < {1'b0, limit_q};
    assign issue     = run_q && kind_runs(kind_q) && in_span;
    assign fire      = issue && req_ready;
    assign finish    = run_q && !issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cur_q <= '0;
        end else if (launch) begin
            run_q <= 1'b1;
            cur_q <= base_line;
        end else if (finish) begin
            run_q <= 1'b0;
        end else if (fire) begin
            cur_q <= cur_q + CUR_W'(LINE_BYTES);
        end
    end

    assign req_valid = issue;
    assign req_addr  = cur_q[ADDR_W-1:0];
    assign req_op    = kind_q;
    assign busy      = run_q;
    assign done      = finish;

endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
    import cmo_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              line_valid,
    output logic [ADDR_W-1:0] line_addr,
    output logic [1:0]        line_op,
    input  logic              line_ready,
    output logic              busy,
    output logic              done
);

    logic [ADDR_W-1:0] first_q, limit_q;
    cmo_op_e           kind_q;
    logic              launch;

    cmo_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .first_q   (first_q),
        .limit_q   (limit_q),
        .kind_q    (kind_q),
        .launch    (launch)
    );

    cmo_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .first_q   (first_q),
        .limit_q   (limit_q),
        .kind_q    (kind_q),
        .req_valid (line_valid),
        .req_addr  (line_addr),
        .req_op    (line_op),
        .req_ready (line_ready),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/cmo_range_engine_chk.sv
module cmo_range_engine_chk #(
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              line_valid,
    input logic [ADDR_W-1:0] line_addr,
    input logic [1:0]        line_op,
    input logic              line_ready,
    input logic              busy,
    input logic              done
);

    localparam int OFS_W = $clog2(LINE_BYTES);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        line_valid && !line_ready |=> line_valid && $stable(line_addr) && $stable(line_op)); // R7

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> line_addr[OFS_W-1:0] == '0); // R5

    AST_STEP_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        line_valid && line_ready |=> !line_valid || line_addr == $past(line_addr) + ADDR_W'(LINE_BYTES)); // R5

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> busy && !done); // R4

    AST_NO_RESERVED_REQ: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> line_op != 2'd3); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy ##1 !busy); // R10

endmodule

bind cmo_range_engine cmo_range_engine_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_valid (line_valid),
    .line_addr  (line_addr),
    .line_op    (line_op),
    .line_ready (line_ready),
    .busy       (busy),
    .done       (done)
);

// File: tb/tb_cmo_range_engine.sv
module tb_cmo_range_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    localparam logic [63:0] AMASK = 64'h0000_00FF_FFFF_FFFF;

    typedef struct packed {
        logic [63:0] first;
        logic [63:0] limit;
        logic [1:0]  kind;
        logic [1:0]  pace;   // 0 always ready, 1 every other cycle, 2 two stalls per accept
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{64'h1000,                64'h1100,        2'd0, 2'd0},
        '{64'h1010,                64'h1041,        2'd1, 2'd1},
        '{64'h2000,                64'h2000,        2'd2, 2'd0},
        '{64'h3040,                64'h3000,        2'd0, 2'd0},
        '{64'h4000,                64'h4200,        2'd3, 2'd0},
        '{64'hFF_FFFF_FFC0,        64'hFF_FFFF_FFFF, 2'd2, 2'd2},
        '{64'hABCD_0000_0000_5000, 64'h5080,        2'd1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        line_valid;
    logic [39:0] line_addr;
    logic [1:0]  line_op;
    logic        line_ready = 1'b0;
    logic        busy, done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmo_range_engine dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_valid(line_valid),
        .line_addr(line_addr), .line_op(line_op), .line_ready(line_ready),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic bit pace_ready(input logic [1:0] pace, input int cyc);
        case (pace)
            2'd1:    return (cyc % 2) == 1;
            2'd2:    return (cyc % 3) == 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        logic [63:0] lim, exp_a, a, rd;
        int exp_n, lines, stalls, cyc;
        bit rdy;
        lim   = v.limit & AMASK;
        exp_a = (v.first & AMASK) & ~64'h3F;
        exp_n = 0;
        a = exp_a;
        while (a < lim) begin a += 64; exp_n++; end
        if (v.kind == 2'd3) exp_n = 0;
        write_reg(5'h00, v.first);
        write_reg(5'h08, v.limit);
        write_reg(5'h10, {61'd0, v.kind, 1'b1});
        check("R4 busy after launch", {63'd0, busy}, 64'd1);
        lines = 0; stalls = 0; cyc = 0;
        while (busy && cyc < 1000) begin
            if (line_valid) begin
                check("R5 line address", {24'd0, line_addr}, exp_a);
                check("R6 line kind", {62'd0, line_op}, {62'd0, v.kind});
                rdy = pace_ready(v.pace, cyc);
                line_ready = rdy;
                if (rdy) begin exp_a += 64; lines++; end
                else stalls++;   // R7: address must stay at exp_a next cycle
            end else begin
                line_ready = 1'b0;
                check("R10 done in last busy cycle", {63'd0, done}, 64'd1);
                check("R8 no line left below limit",
                      {63'd0, (v.kind == 2'd3) || (exp_a >= lim)}, 64'd1);
            end
            @(negedge clk);
            cyc++;
        end
        line_ready = 1'b0;
        check("R5 R8 R9 line count", lines, exp_n);
        check("R10 busy cycles", cyc, exp_n + stalls + 1);
        check("R10 idle after walk", {62'd0, busy, done}, 64'd0);
        read_reg(5'h10, rd);
        check("R3 control readback idle", rd, {61'd0, v.kind, 1'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        int cnt, cyc;

        // reset state (R1)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle outputs", {61'd0, busy, done, line_valid}, 64'd0);
        read_reg(5'h00, rd); check("R1 first reg zero", rd, 64'd0);
        read_reg(5'h08, rd); check("R1 limit reg zero", rd, 64'd0);
        read_reg(5'h10, rd); check("R1 control reg zero", rd, 64'd0);

        // address masking (R2), address writes do not launch (R4)
        write_reg(5'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4 address write no launch", {63'd0, busy}, 64'd0);
        read_reg(5'h00, rd); check("R2 first masked", rd, 64'h0000_00FF_FFFF_FFFF);
        write_reg(5'h08, 64'h1234_5678_9ABC_DEF0);
        read_reg(5'h08, rd); check("R2 limit masked", rd, 64'h0000_0078_9ABC_DEF0);

        // kind stored without launch (R3)
        write_reg(5'h10, 64'hFFFF_0000_0000_0004);
        check("R3 no launch with bit0 clear", {63'd0, busy}, 64'd0);
        read_reg(5'h10, rd); check("R3 kind latched", rd, 64'h4);

        // table-driven walks
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // writes ignored while busy (R11)
        write_reg(5'h00, 64'h8000);
        write_reg(5'h08, 64'h8400);
        write_reg(5'h10, 64'h3);
        read_reg(5'h10, rd); check("R3 control readback busy", rd, 64'h3);
        write_reg(5'h00, 64'h9000);
        write_reg(5'h08, 64'h9040);
        write_reg(5'h10, 64'h5);
        read_reg(5'h00, rd); check("R11 first unchanged", rd, 64'h8000);
        read_reg(5'h08, rd); check("R11 limit unchanged", rd, 64'h8400);
        read_reg(5'h10, rd); check("R11 kind unchanged", rd, 64'h3);
        check("R11 R7 request frozen", {22'd0, line_valid, line_op, line_addr},
              {22'd0, 1'b1, 2'd1, 40'h8000});
        line_ready = 1'b1;
        cnt = 0; cyc = 0;
        while (busy && cyc < 1000) begin
            if (line_valid) cnt++;
            @(negedge clk);
            cyc++;
        end
        line_ready = 1'b0;
        check("R11 original span walked", cnt, 16);

        // reset during a walk (R1)
        write_reg(5'h00, 64'hA000);
        write_reg(5'h08, 64'hB000);
        write_reg(5'h10, 64'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-walk reset idle", {61'd0, busy, done, line_valid}, 64'd0);
        read_reg(5'h10, rd); check("R1 control cleared", rd, 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule